// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block sequences the operating state of a small 8-bit microcontroller core between three modes: running, idle and power-down. It watches the raw external reset pin, qualifies it against the oscillator clock, and produces one synchronised internal reset for the rest of the chip. Software asks for a low-power mode by writing a power control register. The block receives that write as a strobe with two request bits. The enabled interrupt lines feed into the block so that it can wake the core from idle.

Its outputs are enables rather than clocks. It drives a CPU clock gate, a peripheral clock gate and an oscillator enable. It also drives a set of pin overrides. These tell the pad logic what the address-latch strobe, the program-store strobe, the low address/data port and the high address port must do in each low-power mode. One extra output blocks internal RAM writes during the short stretch after idle is ended by the reset pin, before the internal reset has taken hold.

Top module: `pwrc_ctrl`

## Requirements
- R1: After `por_n` is released, the mode is run. `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1. `sys_rst`, `ram_wr_block`, `ale_force`, `psen_force`, `p0_float` and `p2_latch_sel` are 0.
- R2: `rst_pin` passes through a two-stage synchroniser. `sys_rst` rises on the 26th rising clock edge after `rst_pin` goes high: 2 synchroniser edges plus 24 qualifying oscillator periods, which is two machine cycles of 12 periods each. A pulse that is sampled high on fewer than 24 qualifying edges leaves `sys_rst` at 0. `sys_rst` falls on the 3rd edge after `rst_pin` goes low.
- R3: A power control write (`pcon_we`=1) in run mode with `pcon_idle`=1 and `pcon_pdown`=0 enters idle on that edge. In idle, `cpu_clk_en`=0 while `periph_clk_en`=1 and `osc_en`=1.
- R4: In idle, a 1 on any bit of `irq_req` returns the block to run mode on the next edge (`cpu_clk_en`=1). In run mode, `irq_req` has no effect.
- R5: A power control write with `pcon_pdown`=1 enters power-down on that edge, also when `pcon_idle`=1 in the same write. In power-down, `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R6: In power-down, `irq_req` has no effect. After `rst_pin` goes high, `osc_en` returns to 1 on the 3rd edge. `sys_rst` rises on the 27th edge. The mode returns to run on the 28th edge.
- R7: In idle, `ale_force`=1, `ale_level`=1, `psen_force`=1 and `psen_level`=1. In power-down, both forces are 1 and both levels are 0. In run mode, both forces are 0.
- R8: When `ext_prog`=1, `p0_float`=1 in both idle and power-down. `p2_latch_sel` is 0 in idle, so the high port keeps the address, and 1 in power-down, so the high port drives its latched data. When `ext_prog`=0, `p0_float`=0 in every mode.
- R9: When idle is ended by `rst_pin`, the mode becomes run on the 3rd edge after the pin rises. `ram_wr_block` is 1 from that edge until `sys_rst` rises. At the edge where `sys_rst` rises, `ram_wr_block` goes to 0.
- R10: Power control writes are ignored while in idle, while in power-down, and while `sys_rst`=1.
- R11: If an interrupt and the synchronised reset are both seen in the same idle cycle, the block returns to run mode with `ram_wr_block`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset of this block, active low, asynchronous |
| rst_pin | input | 1 | Raw external reset pin, active high |
| pcon_we | input | 1 | Power control register write strobe |
| pcon_idle | input | 1 | Idle request bit of the write |
| pcon_pdown | input | 1 | Power-down request bit of the write |
| irq_req | input | N_IRQ | Enabled interrupt requests |
| ext_prog | input | 1 | Core is fetching from external program memory |
| sys_rst | output | 1 | Qualified internal reset |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_block | output | 1 | Inhibit internal RAM writes |
| ale_force | output | 1 | Override the address-latch strobe pin |
| ale_level | output | 1 | Level for the overridden address-latch strobe |
| psen_force | output | 1 | Override the program-store strobe pin |
| psen_level | output | 1 | Level for the overridden program-store strobe |
| p0_float | output | 1 | Put the low address/data port in high impedance |
| p2_latch_sel | output | 1 | High port drives latched data instead of the address |

## Verification
In idle, the interrupt wake-up and the reset-driven exit can land on the same clock edge. The bench arranges this by raising `rst_pin` and then asserting an interrupt exactly on the edge where the synchronised reset is first sampled. The expected result is run mode with RAM writes blocked. A second clash comes from a single power control write that carries both request bits; that case must end in power-down.

// File: rtl/pwrc_pkg.sv
`timescale 1ns/1ps
package pwrc_pkg;
   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_IDLE  = 2'd1,
      PM_PDOWN = 2'd2
   } pm_state_e;

   function automatic int unsigned qual_len(input int unsigned per_mc,
                                            input int unsigned n_mc);
      return per_mc * n_mc;
   endfunction
endpackage

// File: rtl/pwrc_sync.sv
`timescale 1ns/1ps
module pwrc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwrc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwrc_rst_qual.sv
`timescale 1ns/1ps
module pwrc_rst_qual #(
   parameter int unsigned QUAL_LEN = 24
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_s,
   input  logic osc_run,
   output logic sys_rst
);
   localparam int unsigned CW = (QUAL_LEN > 1) ? $clog2(QUAL_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(QUAL_LEN - 1);

   if (QUAL_LEN < 2) begin : g_bad_len
      $error("pwrc_rst_qual: QUAL_LEN must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          rst_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
         rst_q <= 1'b0;
      end else if (!rst_s) begin
         cnt_q <= '0;
         rst_q <= 1'b0;
      end else if (osc_run) begin
         if (cnt_q == LAST) rst_q <= 1'b1;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sys_rst = rst_q;

   // R2: a low synchronised pin always releases the internal reset
   a_r2_release: assert property (@(posedge clk) disable iff (!arst_n)
      !rst_s |=> !sys_rst);
   // R6: qualification only completes with the oscillator running
   a_r6_needs_osc: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(sys_rst) |-> $past(osc_run));
endmodule

// File: rtl/pwrc_mode_fsm.sv
`timescale 1ns/1ps
module pwrc_mode_fsm
   import pwrc_pkg::*;
#(
   parameter int unsigned N_IRQ = 5
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             rst_s,
   input  logic             sys_rst,
   input  logic             pcon_we,
   input  logic             pcon_idle,
   input  logic             pcon_pdown,
   input  logic [N_IRQ-1:0] irq_req,
   output pm_state_e        state,
   output logic             osc_en,
   output logic             ram_wr_block
);
   if (N_IRQ < 1) begin : g_bad_irq
      $error("pwrc_mode_fsm: N_IRQ must be at least 1");
   end

   logic irq_any;
   if (N_IRQ == 1) begin : g_irq_single
      assign irq_any = irq_req[0];
   end else begin : g_irq_multi
      assign irq_any = |irq_req;
   end

   pm_state_e state_q, state_d;
   logic      osc_q, osc_d;
   logic      blk_q, blk_d;

   always_comb begin
      state_d = state_q;
      if (sys_rst) begin
         state_d = PM_RUN;
      end else begin
         unique case (state_q)
            PM_RUN: begin
               if (pcon_we && pcon_pdown)     state_d = PM_PDOWN;
               else if (pcon_we && pcon_idle) state_d = PM_IDLE;
            end
            PM_IDLE:  if (rst_s || irq_any) state_d = PM_RUN;
            PM_PDOWN: state_d = PM_PDOWN;
            default:  state_d = PM_RUN;
         endcase
      end
   end

   always_comb begin
      if (state_d != PM_PDOWN)      osc_d = 1'b1;
      else if (state_q != PM_PDOWN) osc_d = 1'b0;
      else                          osc_d = rst_s;
   end

   always_comb begin
      if (!rst_s || sys_rst)                    blk_d = 1'b0;
      else if (state_q == PM_IDLE && !sys_rst)  blk_d = 1'b1;
      else                                      blk_d = blk_q;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q <= PM_RUN;
         osc_q   <= 1'b1;
         blk_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         osc_q   <= osc_d;
         blk_q   <= blk_d;
      end
   end

   assign state        = state_q;
   assign osc_en       = osc_q;
   assign ram_wr_block = blk_q & ~sys_rst;

   // R6: power-down is left only through the internal reset
   a_r6_pd_hold: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PM_PDOWN && !sys_rst) |=> (state_q == PM_PDOWN));
   // R4: an interrupt in idle wakes the core
   a_r4_irq_wake: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PM_IDLE && irq_any && !sys_rst) |=> (state_q == PM_RUN));
   // R9: RAM blocking only starts on an idle exit
   a_r9_blk_from_idle: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(ram_wr_block) |-> ($past(state_q) == PM_IDLE));
   // R10: no mode change out of idle by a register write
   a_r10_idle_no_pd: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PM_IDLE) |=> (state_q != PM_PDOWN));
endmodule

// File: rtl/pwrc_pin_ovr.sv
`timescale 1ns/1ps
module pwrc_pin_ovr
   import pwrc_pkg::*;
(
   input  pm_state_e state,
   input  logic      ext_prog,
   output logic      ale_force,
   output logic      ale_level,
   output logic      psen_force,
   output logic      psen_level,
   output logic      p0_float,
   output logic      p2_latch_sel
);
   logic in_idle, in_pd;

   assign in_idle = (state == PM_IDLE);
   assign in_pd   = (state == PM_PDOWN);

   always_comb begin
      ale_force    = in_idle | in_pd;
      psen_force   = in_idle | in_pd;
      ale_level    = in_idle;
      psen_level   = in_idle;
      p0_float     = ext_prog & (in_idle | in_pd);
      p2_latch_sel = in_pd;
   end
endmodule

// File: rtl/pwrc_ctrl.sv
`timescale 1ns/1ps
module pwrc_ctrl
   import pwrc_pkg::*;
#(
   parameter int unsigned OSC_PER_MC  = 12,
   parameter int unsigned QUAL_MC     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned N_IRQ       = 5
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_pin,
   input  logic             pcon_we,
   input  logic             pcon_idle,
   input  logic             pcon_pdown,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic             ext_prog,
   output logic             sys_rst,
   output logic             cpu_clk_en,
   output logic             periph_clk_en,
   output logic             osc_en,
   output logic             ram_wr_block,
   output logic             ale_force,
   output logic             ale_level,
   output logic             psen_force,
   output logic             psen_level,
   output logic             p0_float,
   output logic             p2_latch_sel
);
   localparam int unsigned QUAL_LEN = qual_len(OSC_PER_MC, QUAL_MC);

   if (OSC_PER_MC < 1 || QUAL_MC < 1) begin : g_bad_mc
      $error("pwrc_ctrl: machine cycle parameters must be positive");
   end

   logic      rst_s;
   pm_state_e state;

   pwrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(por_n), .d(rst_pin), .q(rst_s));

   pwrc_rst_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
      .clk(clk), .arst_n(por_n), .rst_s(rst_s), .osc_run(osc_en),
      .sys_rst(sys_rst));

   pwrc_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
      .clk(clk), .arst_n(por_n), .rst_s(rst_s), .sys_rst(sys_rst),
      .pcon_we(pcon_we), .pcon_idle(pcon_idle), .pcon_pdown(pcon_pdown),
      .irq_req(irq_req), .state(state), .osc_en(osc_en),
      .ram_wr_block(ram_wr_block));

   pwrc_pin_ovr u_pins (
      .state(state), .ext_prog(ext_prog),
      .ale_force(ale_force), .ale_level(ale_level),
      .psen_force(psen_force), .psen_level(psen_level),
      .p0_float(p0_float), .p2_latch_sel(p2_latch_sel));

   assign cpu_clk_en    = (state == PM_RUN);
   assign periph_clk_en = (state != PM_PDOWN);

   // R3: an idle write stops only the CPU clock
   a_r3_idle_entry: assert property (@(posedge clk) disable iff (!por_n)
      (pcon_we && pcon_idle && !pcon_pdown && cpu_clk_en && !sys_rst)
      |=> (!cpu_clk_en && periph_clk_en && osc_en));
   // R5: a power-down write wins and stops everything
   a_r5_pd_entry: assert property (@(posedge clk) disable iff (!por_n)
      (pcon_we && pcon_pdown && cpu_clk_en && !sys_rst)
      |=> (!osc_en && !periph_clk_en && !cpu_clk_en));
   // R7: power-down strobe levels
   a_r7_pd_strobes: assert property (@(posedge clk) disable iff (!por_n)
      !periph_clk_en |-> (ale_force && !ale_level && psen_force && !psen_level));
   // R8: external fetch in power-down floats the low port and latches the high port
   a_r8_pd_ports: assert property (@(posedge clk) disable iff (!por_n)
      (!periph_clk_en && ext_prog) |-> (p0_float && p2_latch_sel));
   // R7: no overrides while running
   a_r7_run_free: assert property (@(posedge clk) disable iff (!por_n)
      cpu_clk_en |-> (!ale_force && !psen_force && !p0_float));
endmodule

// File: tb/pwrc_ctrl_tb.sv
`timescale 1ns/1ps
module pwrc_ctrl_tb_top;
   localparam int N_IRQ = 5;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_pin = 1'b0;
   logic pcon_we = 1'b0, pcon_idle = 1'b0, pcon_pdown = 1'b0;
   logic [N_IRQ-1:0] irq_req = '0;
   logic ext_prog = 1'b0;
   logic sys_rst, cpu_clk_en, periph_clk_en, osc_en, ram_wr_block;
   logic ale_force, ale_level, psen_force, psen_level, p0_float, p2_latch_sel;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pwrc_ctrl #(.N_IRQ(N_IRQ)) dut_i (
      .clk(clk), .por_n(por_n), .rst_pin(rst_pin),
      .pcon_we(pcon_we), .pcon_idle(pcon_idle), .pcon_pdown(pcon_pdown),
      .irq_req(irq_req), .ext_prog(ext_prog),
      .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .osc_en(osc_en), .ram_wr_block(ram_wr_block),
      .ale_force(ale_force), .ale_level(ale_level),
      .psen_force(psen_force), .psen_level(psen_level),
      .p0_float(p0_float), .p2_latch_sel(p2_latch_sel));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pcon_write(input logic idl, input logic pd);
      pcon_we = 1'b1; pcon_idle = idl; pcon_pdown = pd;
      tick(1);
      pcon_we = 1'b0; pcon_idle = 1'b0; pcon_pdown = 1'b0;
   endtask

   task automatic pin_reset();
      rst_pin = 1'b1;
      tick(30);
      rst_pin = 1'b0;
      tick(4);
   endtask

   // mode code: {cpu, periph, osc}
   function automatic logic [2:0] mode_bits();
      return {cpu_clk_en, periph_clk_en, osc_en};
   endfunction

   task automatic t_reset_state();
      chk("R1", "clock enables", mode_bits(), 3'b111);
      chk("R1", "sys_rst", sys_rst, 0);
      chk("R1", "ram_wr_block", ram_wr_block, 0);
      chk("R1", "pin overrides", {ale_force, psen_force, p0_float, p2_latch_sel}, 4'b0000);
   endtask

   task automatic t_qualify();
      rst_pin = 1'b1;
      tick(25);
      chk("R2", "sys_rst at edge 25", sys_rst, 0);
      tick(1);
      chk("R2", "sys_rst at edge 26", sys_rst, 1);
      rst_pin = 1'b0;
      tick(2);
      chk("R2", "sys_rst 2 edges after release", sys_rst, 1);
      tick(1);
      chk("R2", "sys_rst 3 edges after release", sys_rst, 0);
      tick(2);
   endtask

   task automatic t_short_pulse();
      logic seen = 1'b0;
      rst_pin = 1'b1;
      for (int i = 0; i < 23; i++) begin tick(1); seen |= sys_rst; end
      rst_pin = 1'b0;
      for (int i = 0; i < 8; i++) begin tick(1); seen |= sys_rst; end
      chk("R2", "short pulse gives no reset", seen, 0);
   endtask

   task automatic t_idle_irq();
      irq_req = 5'b00001;
      tick(1);
      irq_req = '0;
      chk("R4", "irq in run has no effect", mode_bits(), 3'b111);
      pcon_write(1'b1, 1'b0);
      chk("R3", "idle clocks", mode_bits(), 3'b011);
      chk("R7", "idle strobes", {ale_force, ale_level, psen_force, psen_level}, 4'b1111);
      tick(3);
      chk("R3", "idle persists", mode_bits(), 3'b011);
      irq_req = 5'b10000;
      tick(1);
      irq_req = '0;
      chk("R4", "irq wakes idle", mode_bits(), 3'b111);
      chk("R7", "run releases strobes", {ale_force, psen_force}, 2'b00);
   endtask

   task automatic t_pd_priority_and_exit();
      logic seen = 1'b0;
      pcon_write(1'b1, 1'b1);
      chk("R5", "both bits give power-down", mode_bits(), 3'b000);
      chk("R7", "pd strobes", {ale_force, ale_level, psen_force, psen_level}, 4'b1010);
      irq_req = 5'b11111;
      tick(3);
      irq_req = '0;
      tick(1);
      chk("R6", "irq ignored in pd", mode_bits(), 3'b000);
      pcon_write(1'b0, 1'b0);
      chk("R10", "write ignored in pd", mode_bits(), 3'b000);
      rst_pin = 1'b1;
      tick(2);
      chk("R6", "osc still off at edge 2", osc_en, 0);
      tick(1);
      chk("R6", "osc on at edge 3", osc_en, 1);
      for (int i = 0; i < 23; i++) begin tick(1); seen |= sys_rst; end
      chk("R6", "no reset by edge 26", seen, 0);
      chk("R6", "cpu still off at edge 26", cpu_clk_en, 0);
      tick(1);
      chk("R6", "sys_rst at edge 27", sys_rst, 1);
      tick(1);
      chk("R6", "run at edge 28", mode_bits(), 3'b111);
      rst_pin = 1'b0;
      tick(4);
      chk("R6", "reset released", sys_rst, 0);
      pcon_write(1'b0, 1'b1);
      chk("R5", "pd bit alone", mode_bits(), 3'b000);
      pin_reset();
   endtask

   task automatic t_ports();
      ext_prog = 1'b1;
      tick(1);
      chk("R8", "run ports", {p0_float, p2_latch_sel}, 2'b00);
      pcon_write(1'b1, 1'b0);
      chk("R8", "idle ext ports", {p0_float, p2_latch_sel}, 2'b10);
      ext_prog = 1'b0;
      #1;
      chk("R8", "idle int ports", p0_float, 0);
      irq_req = 5'b00100;
      tick(1);
      irq_req = '0;
      ext_prog = 1'b1;
      pcon_write(1'b0, 1'b1);
      chk("R8", "pd ext ports", {p0_float, p2_latch_sel}, 2'b11);
      ext_prog = 1'b0;
      #1;
      chk("R8", "pd int ports", {p0_float, p2_latch_sel}, 2'b01);
      pin_reset();
   endtask

   task automatic t_idle_reset();
      pcon_write(1'b1, 1'b0);
      pcon_write(1'b0, 1'b1);
      chk("R10", "pd write ignored in idle", mode_bits(), 3'b011);
      rst_pin = 1'b1;
      tick(2);
      chk("R9", "still idle at edge 2", cpu_clk_en, 0);
      tick(1);
      chk("R9", "run at edge 3", cpu_clk_en, 1);
      chk("R9", "ram blocked at edge 3", ram_wr_block, 1);
      tick(22);
      chk("R9", "ram blocked at edge 25", ram_wr_block, 1);
      tick(1);
      chk("R9", "sys_rst at edge 26", sys_rst, 1);
      chk("R9", "ram free at edge 26", ram_wr_block, 0);
      pcon_write(1'b1, 1'b0);
      chk("R10", "write ignored during reset", mode_bits(), 3'b111);
      rst_pin = 1'b0;
      tick(4);
   endtask

   task automatic t_same_cycle();
      pcon_write(1'b1, 1'b0);
      rst_pin = 1'b1;
      tick(2);
      irq_req = 5'b01000;
      tick(1);
      irq_req = '0;
      chk("R11", "run after joint exit", cpu_clk_en, 1);
      chk("R11", "ram blocked after joint exit", ram_wr_block, 1);
      rst_pin = 1'b0;
      tick(4);
      chk("R11", "block clears after short reset", ram_wr_block, 0);
   endtask

   initial begin
      tick(2);
      por_n = 1'b1;
      tick(2);
      t_reset_state();
      t_qualify();
      t_short_pulse();
      t_idle_irq();
      t_pd_priority_and_exit();
      t_ports();
      t_idle_reset();
      t_same_cycle();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule